// File: doc/BRIEF.md
# Warp issue controller

This block picks one instruction per cycle from a handful of warps that share one dispatcher. Every instruction arrives with a 21-bit control section already decoded and placed beside it. The compiler writes into that section everything the hardware needs to keep the warp correct: how many cycles to hold the warp after it issues, whether the scheduler should stay on the warp, which dependency barrier a long-latency result or an unbuffered store will clear, and which barriers the instruction has to wait for. The controller enforces these fields. It keeps no register scoreboard.

Each warp owns six barriers. Each barrier is a small saturating counter. It goes up when an issuing instruction names it and goes down when a variable-latency unit returns a completion pulse tagged with the same warp and barrier. Among the warps that may issue, the controller first honours the yield preference and then goes round-robin, starting after the warp that issued last. The chosen control section leaves the block unchanged, together with the warp number and an issue strobe. An instruction is consumed in the cycle its warp is reported on the issue strobe.

Top module: `warp_issue_ctl`

## Requirements
- R1: The control section is packed with the stall count at bits [3:0], the yield flag at bit 4, the write-barrier index at [7:5], the read-barrier index at [10:8], the wait mask at [16:11] (bit n stands for barrier n) and the reuse mask at [20:17]. When an instruction issues, issue_ctrl carries exactly the section presented by that warp, and each warp's instructions issue in the order they were presented.
- R2: At most one instruction issues per cycle, and only from a warp whose inst_valid bit is high.
- R3: When a warp issues with stall count S, its next instruction issues no earlier than S+1 cycles later. With the yield flag set and nothing else in the way, it issues exactly S+1 cycles later.
- R4: An issue with the yield flag clear is followed by one cycle in which nothing issues. After that cycle, the next warp in round-robin order after the issuer gets priority.
- R5: An issue with the yield flag set lets the same warp issue again in the next allowed cycle, ahead of every other warp.
- R6: Without a yield preference, the winner is the first eligible warp counting upward from the last issuer and wrapping around. After reset, warp 0 has first priority.
- R7: A write-barrier index from 0 to 5 raises that barrier of the issuing warp by one. A completion pulse naming the warp and the barrier lowers it by one.
- R8: A read-barrier index from 0 to 5 raises that barrier in the same way. When both indices name the same barrier, it is raised twice.
- R9: An instruction does not issue while any barrier selected by its wait mask is nonzero. Bits for barriers that are already zero do not hold it back. It issues in the cycle after the completion that clears the last barrier it is waiting on, provided nothing else blocks it.
- R10: Index values 6 and 7, in either barrier field or in cpl_bar, name no barrier and change nothing.
- R11: A barrier counter saturates at 2^CNT_W-1 and never wraps to zero.
- R12: A completion aimed at a counter that is already zero is ignored. Barriers belong to one warp only: a completion for one warp never clears another warp's barrier, and a warp blocked on a barrier never stops other warps from issuing.
- R13: During and right after reset nothing issues unless an instruction is presented, and all stall and barrier counters start at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | NWARPS | A warp presents an instruction |
| inst_ctrl | input | NWARPS*21 | Control section per warp; warp w uses bits [w*21 +: 21] |
| cpl_valid | input | 1 | Completion pulse from a variable-latency unit |
| cpl_warp | input | WID | Warp named by the completion |
| cpl_bar | input | 3 | Barrier named by the completion |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WID | Warp that issues |
| issue_ctrl | output | 21 | Control section of the issued instruction |

## Verification
The bench builds the controller with four warps, so the round-robin pointer wraps and several warps compete within a few cycles. It also sets CNT_W to 3, so a counter saturates after eight issues naming one barrier, and the bench can then show that seven completions, not eight, release a waiter. A responder returns completions after a delay that depends on the barrier number, which makes the release cycle of every waiting instruction a fixed number. It can also be switched off so that completions are injected by hand to probe zero counters, other warps' barriers and the reserved indices.

// File: rtl/warp_issue_ctl.sv
module warp_issue_ctl #(
  parameter int NWARPS = 4,
  parameter int CNT_W  = 4,
  localparam int WID   = (NWARPS > 1) ? $clog2(NWARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NWARPS-1:0]    inst_valid,
  input  logic [NWARPS*21-1:0] inst_ctrl,
  input  logic                 cpl_valid,
  input  logic [WID-1:0]       cpl_warp,
  input  logic [2:0]           cpl_bar,
  output logic                 issue_valid,
  output logic [WID-1:0]       issue_warp,
  output logic [20:0]          issue_ctrl
);
  localparam int CW   = 21;
  localparam int NB   = 6;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic [WID-1:0] last_w;
  logic last_yield, bubble, found;
  logic [WID-1:0] pick;
  logic [NWARPS-1:0] elig;
  logic [NWARPS*NB-1:0] busy;
  logic [NWARPS*NB*CNT_W-1:0] cnt_flat;

  wire       iss_yield = issue_ctrl[4];
  wire [3:0] iss_stall = issue_ctrl[3:0];
  wire [2:0] iss_wr    = issue_ctrl[7:5];
  wire [2:0] iss_rd    = issue_ctrl[10:8];

  for (genvar w = 0; w < NWARPS; w++) begin : g_warp
    logic [3:0] stl;
    logic mine;
    assign mine = issue_valid && (issue_warp == WID'(w));

    always_ff @(posedge clk) begin
      if (!rst_n)          stl <= 4'd0;
      else if (mine)       stl <= iss_stall;
      else if (stl != 0)   stl <= stl - 4'd1;
    end

    assign elig[w] = inst_valid[w] && (stl == 4'd0) &&
                     ((inst_ctrl[w*CW+11 +: NB] & busy[w*NB +: NB]) == '0);

    for (genvar b = 0; b < NB; b++) begin : g_bar
      logic [CNT_W-1:0] cnt;
      logic [CNT_W+1:0] sum;
      logic [1:0] inc;
      logic dec;

      assign inc = mine ? ({1'b0, iss_wr == 3'(b)} + {1'b0, iss_rd == 3'(b)}) : 2'd0;
      assign dec = cpl_valid && (cpl_warp == WID'(w)) && (cpl_bar == 3'(b)) && (cnt != '0);
      assign sum = {2'b00, cnt} + (CNT_W+2)'(inc) - (CNT_W+2)'(dec);

      always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= (sum > (CNT_W+2)'(CMAX)) ? CNT_W'(CMAX) : sum[CNT_W-1:0];
      end

      assign busy[w*NB+b] = (cnt != '0);
      assign cnt_flat[(w*NB+b)*CNT_W +: CNT_W] = cnt;
    end
  end

  always_comb begin
    found = 1'b0;
    pick  = last_w;
    if (last_yield && elig[last_w]) found = 1'b1;
    for (int k = 1; k <= NWARPS; k++) begin
      int idx;
      logic [WID-1:0] ix;
      idx = int'(last_w) + k;
      if (idx >= NWARPS) idx = idx - NWARPS;
      ix = WID'(idx);
      if (!found && elig[ix]) begin
        found = 1'b1;
        pick  = ix;
      end
    end
  end

  assign issue_valid = found && !bubble;
  assign issue_warp  = pick;
  assign issue_ctrl  = inst_ctrl[pick*CW +: CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_w     <= WID'(NWARPS-1);
      last_yield <= 1'b0;
      bubble     <= 1'b0;
    end else begin
      bubble <= issue_valid && !iss_yield;
      if (issue_valid) begin
        last_w     <= issue_warp;
        last_yield <= iss_yield;
      end
    end
  end
endmodule

// File: rtl/warp_issue_chk.sv
module warp_issue_chk #(
  parameter int NWARPS = 4,
  parameter int CNT_W  = 4,
  localparam int WID   = (NWARPS > 1) ? $clog2(NWARPS) : 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NWARPS-1:0]            inst_valid,
  input logic                         issue_valid,
  input logic [WID-1:0]               issue_warp,
  input logic [5:0]                   ctl_wait,
  input logic                         ctl_yield,
  input logic [3:0]                   ctl_stall,
  input logic [NWARPS*6-1:0]          busy,
  input logic [NWARPS*6*CNT_W-1:0]    cnt_flat
);
  localparam int NB   = 6;
  localparam int CMAX = (1 << CNT_W) - 1;

  // R2
  issue_from_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> inst_valid[issue_warp]);

  // R3
  stall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && ctl_stall != 4'd0) |=> !(issue_valid && issue_warp == $past(issue_warp)));

  // R4
  yield_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !ctl_yield) |=> !issue_valid);

  // R9
  wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ((ctl_wait & busy[issue_warp*NB +: NB]) == 6'd0));

  for (genvar i = 0; i < NWARPS*NB; i++) begin : g_cnt
    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_flat[i*CNT_W +: CNT_W]) == CNT_W'(CMAX)) |->
      (cnt_flat[i*CNT_W +: CNT_W] >= CNT_W'(CMAX-1)));

    // R12
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_flat[i*CNT_W +: CNT_W]) == '0) |->
      (cnt_flat[i*CNT_W +: CNT_W] <= CNT_W'(2)));
  end
endmodule

bind warp_issue_ctl warp_issue_chk #(.NWARPS(NWARPS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid),
  .issue_valid(issue_valid), .issue_warp(issue_warp),
  .ctl_wait(issue_ctrl[16:11]), .ctl_yield(issue_ctrl[4]), .ctl_stall(issue_ctrl[3:0]),
  .busy(busy), .cnt_flat(cnt_flat)
);

// File: tb/tb_warp_issue_ctl.sv
module tb_warp_issue_ctl;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NW-1:0]    inst_valid = '0;
  logic [NW*21-1:0] inst_ctrl  = '0;
  logic             cpl_valid  = 1'b0;
  logic [1:0]       cpl_warp   = '0;
  logic [2:0]       cpl_bar    = '0;
  wire              issue_valid;
  wire  [1:0]       issue_warp;
  wire  [20:0]      issue_ctrl;

  warp_issue_ctl #(.NWARPS(NW), .CNT_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_ctrl(inst_ctrl),
    .cpl_valid(cpl_valid), .cpl_warp(cpl_warp), .cpl_bar(cpl_bar),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_ctrl(issue_ctrl)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [20:0] q [NW][32];
  int q_len [NW];
  int q_ptr [NW];
  int lg_cyc [128];
  int lg_w [128];
  logic [20:0] lg_c [128];
  int n_lg = 0;
  int p_due [64];
  int p_w [64];
  int p_b [64];
  bit p_v [64];
  bit run = 0, auto_cpl = 0;
  int cyc = 0, last_cpl_cyc = 0;

  function automatic logic [20:0] mk(input logic [3:0] ru, input logic [5:0] wt,
                                     input logic [2:0] rd, input logic [2:0] wr,
                                     input logic y, input logic [3:0] s);
    return {ru, wt, rd, wr, y, s};
  endfunction

  function automatic int lat(input int b);
    return 4 + 5*b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_pend(input int due, input int w, input int b);
    for (int i = 0; i < 64; i++) begin
      if (!p_v[i]) begin
        p_v[i] = 1; p_due[i] = due; p_w[i] = w; p_b[i] = b;
        return;
      end
    end
  endtask

  always begin : driver
    int sel;
    int w;
    @(negedge clk);
    #1;
    cyc++;
    for (int k = 0; k < NW; k++) begin
      inst_valid[k] = run && (q_ptr[k] < q_len[k]);
      inst_ctrl[k*21 +: 21] = inst_valid[k] ? q[k][q_ptr[k]] : 21'd0;
    end
    sel = -1;
    for (int i = 0; i < 64; i++)
      if (p_v[i] && p_due[i] <= cyc && (sel < 0 || p_due[i] < p_due[sel])) sel = i;
    if (sel >= 0) begin
      cpl_valid = 1'b1; cpl_warp = 2'(p_w[sel]); cpl_bar = 3'(p_b[sel]);
      p_v[sel] = 0; last_cpl_cyc = cyc;
    end else begin
      cpl_valid = 1'b0; cpl_warp = '0; cpl_bar = '0;
    end
    #2;
    if (issue_valid) begin
      w = int'(issue_warp);
      if (n_lg < 128) begin
        lg_cyc[n_lg] = cyc; lg_w[n_lg] = w; lg_c[n_lg] = issue_ctrl; n_lg++;
      end
      if (auto_cpl) begin
        if (issue_ctrl[7:5] < 3'd6)  add_pend(cyc + lat(int'(issue_ctrl[7:5])), w, int'(issue_ctrl[7:5]));
        if (issue_ctrl[10:8] < 3'd6) add_pend(cyc + lat(int'(issue_ctrl[10:8])), w, int'(issue_ctrl[10:8]));
      end
      q_ptr[w]++;
    end
  end

  task automatic do_reset;
    run = 0; auto_cpl = 0;
    for (int i = 0; i < 64; i++) p_v[i] = 0;
    for (int w = 0; w < NW; w++) begin q_len[w] = 0; q_ptr[w] = 0; end
    n_lg = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input int w, input logic [20:0] c);
    q[w][q_len[w]] = c;
    q_len[w]++;
  endtask

  function automatic bit all_done();
    for (int w = 0; w < NW; w++) if (q_ptr[w] < q_len[w]) return 0;
    return 1;
  endfunction

  function automatic bit any_pend();
    for (int i = 0; i < 64; i++) if (p_v[i]) return 1;
    return 0;
  endfunction

  task automatic go(input int maxc);
    run = 1;
    for (int i = 0; i < maxc && !all_done(); i++) @(negedge clk);
    run = 0;
    for (int i = 0; i < 200 && any_pend(); i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < 200 && any_pend(); i++) @(negedge clk);
    repeat (n) @(negedge clk);
  endtask

  // R1: every issued section matches the presented one, in per-warp order
  task automatic check_pass(input string tag);
    int k [NW];
    int bad;
    bad = 0;
    for (int w = 0; w < NW; w++) k[w] = 0;
    for (int i = 0; i < n_lg; i++) begin
      if (lg_c[i] !== q[lg_w[i]][k[lg_w[i]]]) bad++;
      k[lg_w[i]]++;
    end
    chk(bad == 0, {"R1 section passthrough ", tag}, bad, 0);
  endtask

  task automatic t_reset;
    do_reset();
    run = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #3;
      chk(issue_valid == 1'b0, "R13 idle after reset", int'(issue_valid), 0);
    end
    run = 0;
  endtask

  task automatic t_stall;
    int s [6] = '{3, 0, 7, 15, 1, 0};
    do_reset();
    for (int i = 0; i < 6; i++) load(0, mk(4'(i), 6'd0, 3'd7, 3'd7, 1'b1, 4'(s[i])));
    go(200);
    chk(n_lg == 6, "R3 stall count issued", n_lg, 6);
    for (int i = 1; i < 6 && i < n_lg; i++)
      chk(lg_cyc[i] - lg_cyc[i-1] == s[i-1] + 1, "R3 stall gap", lg_cyc[i] - lg_cyc[i-1], s[i-1] + 1);
    check_pass("stall");
  endtask

  task automatic t_yield;
    int gexp [3] = '{2, 2, 6};
    do_reset();
    load(0, mk(4'd1, 6'd0, 3'd7, 3'd7, 1'b0, 4'd0));
    load(0, mk(4'd2, 6'd0, 3'd7, 3'd7, 1'b0, 4'd0));
    load(0, mk(4'd3, 6'd0, 3'd7, 3'd7, 1'b0, 4'd5));
    load(0, mk(4'd4, 6'd0, 3'd7, 3'd7, 1'b0, 4'd0));
    go(100);
    chk(n_lg == 4, "R4 yield-clear issued", n_lg, 4);
    for (int i = 1; i < 4 && i < n_lg; i++)
      chk(lg_cyc[i] - lg_cyc[i-1] == gexp[i-1], "R4 switch bubble gap", lg_cyc[i] - lg_cyc[i-1], gexp[i-1]);
    check_pass("yield");
  endtask

  task automatic t_rr;
    int bad;
    do_reset();
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < NW; w++) load(w, mk(4'(w), 6'd0, 3'd7, 3'd7, 1'b0, 4'd0));
    go(100);
    chk(n_lg == 8, "R6 round-robin issued", n_lg, 8);
    chk(n_lg > 0 && lg_w[0] == 0, "R6 warp 0 first after reset", lg_w[0], 0);
    bad = 0;
    for (int i = 0; i < n_lg; i++) if (lg_w[i] != i % NW) bad++;
    chk(bad == 0, "R6 rotation order", bad, 0);
    bad = 0;
    for (int i = 1; i < n_lg; i++) if (lg_cyc[i] - lg_cyc[i-1] != 2) bad++;
    chk(bad == 0, "R4 one idle cycle per switch", bad, 0);
    check_pass("rr");
  endtask

  task automatic t_keep;
    int bad;
    do_reset();
    for (int w = 0; w < NW; w++) begin
      load(w, mk(4'(w), 6'd0, 3'd7, 3'd7, 1'b1, 4'd0));
      load(w, mk(4'(w+8), 6'd0, 3'd7, 3'd7, 1'b1, 4'd0));
    end
    go(100);
    chk(n_lg == 8, "R5 yield-set issued", n_lg, 8);
    bad = 0;
    for (int i = 0; i < n_lg; i++) if (lg_w[i] != i / 2) bad++;
    chk(bad == 0, "R5 stays on warp", bad, 0);
    bad = 0;
    for (int i = 1; i < n_lg; i++) if (lg_cyc[i] - lg_cyc[i-1] != 1) bad++;
    chk(bad == 0, "R5 back-to-back", bad, 0);
    check_pass("keep");
  endtask

  task automatic t_wait1;
    do_reset();
    auto_cpl = 1;
    load(0, mk(4'd5, 6'd0, 3'd7, 3'd2, 1'b1, 4'd0));
    load(0, mk(4'd6, 6'b000100, 3'd7, 3'd7, 1'b1, 4'd0));
    for (int i = 0; i < 3; i++) load(1, mk(4'(i), 6'd0, 3'd7, 3'd7, 1'b1, 4'd2));
    go(200);
    chk(n_lg == 5, "R7 write barrier scenario issued", n_lg, 5);
    if (n_lg == 5) begin
      chk(lg_w[4] == 0 && lg_cyc[4] == lg_cyc[0] + lat(2) + 1, "R9 waiter released after completion",
          lg_cyc[4] - lg_cyc[0], lat(2) + 1);
      chk(lg_w[1] == 1 && lg_cyc[1] == lg_cyc[0] + 1, "R12 other warp not blocked", lg_cyc[1] - lg_cyc[0], 1);
      chk(lg_cyc[3] - lg_cyc[1] == 6, "R3 other warp stall spacing", lg_cyc[3] - lg_cyc[1], 6);
    end
    check_pass("wait1");
  endtask

  task automatic t_wait2;
    int e;
    do_reset();
    auto_cpl = 1;
    load(0, mk(4'd1, 6'd0, 3'd7, 3'd1, 1'b1, 4'd0));
    load(0, mk(4'd2, 6'd0, 3'd4, 3'd7, 1'b1, 4'd0));
    load(0, mk(4'd3, 6'b010011, 3'd7, 3'd7, 1'b1, 4'd0));
    load(0, mk(4'd4, 6'd0, 3'd3, 3'd3, 1'b1, 4'd0));
    load(0, mk(4'd5, 6'b001000, 3'd7, 3'd7, 1'b1, 4'd0));
    go(300);
    chk(n_lg == 5, "R8 read barrier scenario issued", n_lg, 5);
    if (n_lg == 5) begin
      e = ((lg_cyc[0] + lat(1) > lg_cyc[1] + lat(4)) ? lg_cyc[0] + lat(1) : lg_cyc[1] + lat(4)) + 1;
      chk(lg_cyc[2] == e, "R9 multi-bit wait mask", lg_cyc[2], e);
      chk(lg_cyc[4] == lg_cyc[3] + lat(3) + 2, "R8 read and write on one barrier count twice",
          lg_cyc[4] - lg_cyc[3], lat(3) + 2);
    end
    check_pass("wait2");
  endtask

  task automatic t_reserved;
    do_reset();
    auto_cpl = 1;
    load(0, mk(4'd7, 6'd0, 3'd7, 3'd6, 1'b1, 4'd0));
    load(0, mk(4'd8, 6'd0, 3'd6, 3'd6, 1'b1, 4'd0));
    load(0, mk(4'd9, 6'h3F, 3'd7, 3'd7, 1'b1, 4'd0));
    go(100);
    chk(n_lg == 3, "R10 reserved index issued", n_lg, 3);
    if (n_lg == 3)
      chk(lg_cyc[2] == lg_cyc[0] + 2, "R10 indices 6 and 7 hold nothing", lg_cyc[2] - lg_cyc[0], 2);
    check_pass("reserved");
  endtask

  task automatic t_sat;
    do_reset();
    for (int i = 0; i < 9; i++) load(0, mk(4'(i), 6'd0, 3'd7, 3'd0, 1'b1, 4'd0));
    load(0, mk(4'd15, 6'b000001, 3'd7, 3'd7, 1'b1, 4'd0));
    run = 1;
    for (int i = 0; i < 100 && n_lg < 9; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_lg == 9, "R11 waiter held by saturated counter", n_lg, 9);
    for (int i = 0; i < 6; i++) add_pend(cyc, 0, 0);
    settle(3);
    chk(n_lg == 9, "R11 six completions leave counter nonzero", n_lg, 9);
    add_pend(cyc, 0, 0);
    settle(3);
    chk(n_lg == 10, "R11 seventh completion clears saturated counter", n_lg, 10);
    if (n_lg == 10)
      chk(lg_cyc[9] == last_cpl_cyc + 1, "R9 release cycle after saturation", lg_cyc[9] - last_cpl_cyc, 1);
    run = 0;
    check_pass("sat");
  endtask

  task automatic t_zero;
    do_reset();
    add_pend(cyc, 0, 3); add_pend(cyc, 0, 3); add_pend(cyc, 1, 3);
    settle(3);
    load(0, mk(4'd2, 6'd0, 3'd7, 3'd3, 1'b1, 4'd0));
    load(0, mk(4'd3, 6'b001000, 3'd7, 3'd7, 1'b1, 4'd0));
    run = 1;
    repeat (5) @(negedge clk);
    chk(n_lg == 1, "R12 completions on zero counter ignored", n_lg, 1);
    add_pend(cyc, 1, 3); add_pend(cyc, 0, 6); add_pend(cyc, 0, 7);
    settle(3);
    chk(n_lg == 1, "R12 other warp or reserved completion does not clear", n_lg, 1);
    add_pend(cyc, 0, 3);
    settle(3);
    chk(n_lg == 2, "R7 matching completion clears barrier", n_lg, 2);
    if (n_lg == 2)
      chk(lg_cyc[1] == last_cpl_cyc + 1, "R9 release in cycle after completion", lg_cyc[1] - last_cpl_cyc, 1);
    run = 0;
    check_pass("zero");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    for (int w = 0; w < NW; w++) begin q_len[w] = 0; q_ptr[w] = 0; end
    for (int i = 0; i < 64; i++) p_v[i] = 0;
    t_reset();
    t_stall();
    t_yield();
    t_rr();
    t_keep();
    t_wait1();
    t_wait2();
    t_reserved();
    t_sat();
    t_zero();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule